// File: doc/BRIEF.md
# Delta-Correlating Load Prefetcher

This block watches the stream of load accesses, each given as the program counter of the load and the cache-block address it touched. For every load it keeps a small ring of the most recent non-zero address steps. When the newest two steps have been seen together before in that ring, the steps that followed the earlier pair are replayed from the current address to predict the blocks the load will want next.

Predicted blocks pass through a filter before they are issued. A block already prefetched last by the same load stops the replay from issuing anything produced before it. A block that the cache already holds, or that an outstanding demand miss already covers, is dropped. The cache and the miss-status registers are outside the block and are asked through a query port that answers in the same cycle. Survivors enter a bounded issue queue that a memory-side consumer drains.

A single engine handles one access at a time. It lowers its ready output while it correlates, walks the replayed steps one per cycle, and moves the survivors into the queue.

Top module: `dcpt_prefetcher`

## Requirements
- R1: After reset the issue queue is empty (`pf_valid` low), `acc_ready` is high, `qry_valid` is low and the table holds no loads.
- R2: The table has 8 fully associative entries keyed by load PC. An access whose PC is absent takes over the least recently used entry, which keeps the access address as its last address with every step cleared, and it issues nothing. Both hits and allocations count as uses.
- R3: An access whose address equals its entry's last address leaves the entry's history unchanged, issues nothing and keeps `acc_ready` high.
- R4: A step is the current address minus the last address, stored as an 8-bit two's complement value (-128 to 127). A step outside that range is stored as 0. A zero step never takes part in a match, so a newest pair containing a zero yields no prefetch.
- R5: Each entry keeps its 6 newest steps. Call the newest pair (older, newer) P. The search looks for P among earlier adjacent pairs of the ring, newest occurrence first, and the nearest pair may overlap P by one step. On a match, the steps that follow the matched pair, up to and including the newest step, are added cumulatively to the last address, each sum being one candidate.
- R6: A candidate equal to the block this load last issued discards itself and every candidate of the same replay produced before it. Candidates produced later in that replay are still kept.
- R7: A candidate for which `qry_in_cache` is high in its query cycle is dropped.
- R8: A candidate for which `qry_in_mshr` is high in its query cycle is dropped.
- R9: Surviving candidates enter a 32-entry queue in generation order, and each entry is recorded as the load's last-issued block. `pf_addr` shows the oldest entry and a cycle with `pf_valid` and `pf_ready` high removes it. A push into a full queue discards the oldest entry.
- R10: `acc_ready` is low from the accept of an access with a non-zero step until its replay is queued. That span is 1 + k + max(s,1) cycles for k candidates and s survivors, or 1 cycle when no match is found. `qry_valid` is high only in the k candidate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Load access offered |
| acc_ready | output | 1 | Engine idle, access accepted this cycle |
| acc_pc | input | 32 | Program counter of the load |
| acc_addr | input | 32 | Cache-block address of the load |
| qry_valid | output | 1 | A candidate is being looked up |
| qry_addr | output | 32 | Candidate block under lookup |
| qry_in_cache | input | 1 | Candidate block already cached (same cycle) |
| qry_in_mshr | input | 1 | Candidate block covered by an outstanding miss (same cycle) |
| pf_valid | output | 1 | Issue queue not empty |
| pf_ready | input | 1 | Consumer takes the head entry |
| pf_addr | output | 32 | Oldest queued prefetch block |

## Verification
An accepted access with a non-zero step lowers `acc_ready` for exactly 1 + k + max(s,1) cycles: one search cycle, one query cycle per candidate, and the transfer cycles. The last transfer lands in the queue on the same edge that raises `acc_ready` again. The bench counts the falling-edge samples with `acc_ready` low after each accept and compares that count with the formula. It reads the queue only once `acc_ready` has returned, so every survivor is at the head by then. Allocations and zero steps must show a count of zero. Pops are one-cycle `pf_ready` pulses driven between edges, and the head is compared before each one.

// File: rtl/dcpt_pkg.sv
package dcpt_pkg;

    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_PC_W    = 32;
    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_NDELTA  = 6;
    localparam int unsigned DEF_DELTA_W = 8;
    localparam int unsigned DEF_QDEPTH  = 32;

    // engine phases: accept, correlate, replay candidates, move survivors to queue
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_GEN    = 2'd2,
        ST_FLUSH  = 2'd3
    } eng_state_e;

endpackage

// File: rtl/dcpt_lru.sv
// Age-ordered replacement tracker: age 0 = most recent, N-1 = victim.
module dcpt_lru #(
    parameter int unsigned N = 8,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim
);

    logic [N-1:0][IW-1:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age_d[i] = '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_d[i] = age_q[i] + IW'(1);
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++) begin
            if (age_q[i] == IW'(N - 1))
                victim = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
        end else begin
            age_q <= age_d;
        end
    end

endmodule

// File: rtl/dcpt_corr.sv
// Finds the newest earlier occurrence of the newest step pair.
// by_age[0] is the newest step; a match at k means by_age[k+1],by_age[k]
// equals by_age[1],by_age[0].
module dcpt_corr #(
    parameter int unsigned NDELTA  = 6,
    parameter int unsigned DELTA_W = 8,
    localparam int unsigned HW = $clog2(NDELTA)
) (
    input  logic [NDELTA-1:0][DELTA_W-1:0] by_age,
    output logic                           found,
    output logic [HW-1:0]                  match_age
);

    logic [NDELTA-1:0] eq;
    logic              pair_ok;

    assign pair_ok = (by_age[0] != '0) && (by_age[1] != '0);

    assign eq[0]        = 1'b0;
    assign eq[NDELTA-1] = 1'b0;

    for (genvar k = 1; k < NDELTA - 1; k++) begin : g_cmp
        assign eq[k] = pair_ok && (by_age[k+1] == by_age[1]) && (by_age[k] == by_age[0]);
    end

    // nearest occurrence wins: scan far to near, last hit kept
    always_comb begin
        found     = 1'b0;
        match_age = '0;
        for (int k = NDELTA - 2; k >= 1; k--) begin
            if (eq[k]) begin
                found     = 1'b1;
                match_age = HW'(k);
            end
        end
    end

endmodule

// File: rtl/dcpt_pfq.sv
// Prefetch issue queue; a push into a full queue retires the oldest entry.
module dcpt_pfq #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned W     = 32,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_d, q_q;
    logic pop_eff, full, drop;

    assign out_valid = (q_q.cnt != '0);
    assign out_data  = q_q.mem[q_q.rd];
    assign full      = (q_q.cnt == CW'(DEPTH));
    assign pop_eff   = pop && out_valid;
    assign drop      = push && full && !pop_eff;

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.mem[q_q.wr] = push_data;
            q_d.wr          = q_q.wr + PW'(1);
        end
        if (pop_eff || drop)
            q_d.rd = q_q.rd + PW'(1);
        if (push && !pop_eff && !full)
            q_d.cnt = q_q.cnt + CW'(1);
        else if (!push && pop_eff)
            q_d.cnt = q_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

endmodule

// File: rtl/dcpt_prefetcher.sv
module dcpt_prefetcher
    import dcpt_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned PC_W    = DEF_PC_W,
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned NDELTA  = DEF_NDELTA,
    parameter int unsigned DELTA_W = DEF_DELTA_W,
    parameter int unsigned QDEPTH  = DEF_QDEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              qry_valid,
    output logic [ADDR_W-1:0] qry_addr,
    input  logic              qry_in_cache,
    input  logic              qry_in_mshr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int unsigned IW  = $clog2(ENTRIES);
    localparam int unsigned HW  = $clog2(NDELTA);
    localparam int unsigned CBN = NDELTA - 2;          // most candidates a replay can make
    localparam int unsigned CIW = $clog2(CBN);
    localparam int unsigned CBW = $clog2(CBN + 1);

    typedef struct packed {
        logic                          valid;
        logic [PC_W-1:0]               pc;
        logic [ADDR_W-1:0]             lastb;
        logic [NDELTA-1:0][DELTA_W-1:0] dl;
        logic [HW-1:0]                 head;
        logic                          lpf_ok;
        logic [ADDR_W-1:0]             lpf;
    } ent_t;

    typedef struct packed {
        eng_state_e                 st;
        ent_t [ENTRIES-1:0]         tbl;
        logic [IW-1:0]              sel;
        logic [HW-1:0]              age;
        logic [ADDR_W-1:0]          prev;
        logic [CBN-1:0][ADDR_W-1:0] cbuf;
        logic [CBW-1:0]             ccnt;
        logic [CBW-1:0]             fidx;
    } st_t;

    st_t s_d, s_q;

    // ---------------- lookup by PC ----------------
    logic          hit;
    logic [IW-1:0] hit_idx;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (s_q.tbl[i].valid && s_q.tbl[i].pc == acc_pc) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    // ---------------- step computation and encoding ----------------
    logic [ADDR_W-1:0]  diff;
    logic               fits;
    logic [DELTA_W-1:0] enc;
    logic [HW-1:0]      head_nx;

    assign diff    = acc_addr - s_q.tbl[hit_idx].lastb;
    assign fits    = (&diff[ADDR_W-1:DELTA_W-1]) || !(|diff[ADDR_W-1:DELTA_W-1]);
    assign enc     = fits ? diff[DELTA_W-1:0] : '0;
    assign head_nx = (s_q.tbl[hit_idx].head == HW'(NDELTA - 1)) ? '0
                                                                 : s_q.tbl[hit_idx].head + HW'(1);

    // ---------------- history of the selected entry, newest first ----------------
    logic [HW-1:0]                  cur_head;
    logic [NDELTA-1:0][DELTA_W-1:0] cur_dl;
    logic [NDELTA-1:0][DELTA_W-1:0] by_age;

    assign cur_head = s_q.tbl[s_q.sel].head;
    assign cur_dl   = s_q.tbl[s_q.sel].dl;

    for (genvar a = 0; a < NDELTA; a++) begin : g_age
        logic [HW-1:0] ix;
        assign ix = (32'(cur_head) >= a) ? HW'(32'(cur_head) - a)
                                         : HW'(32'(cur_head) + NDELTA - a);
        assign by_age[a] = cur_dl[ix];
    end

    logic          found;
    logic [HW-1:0] match_age;

    dcpt_corr #(
        .NDELTA  (NDELTA),
        .DELTA_W (DELTA_W)
    ) u_corr (
        .by_age    (by_age),
        .found     (found),
        .match_age (match_age)
    );

    // ---------------- candidate arithmetic ----------------
    logic [DELTA_W-1:0] step;
    logic [ADDR_W-1:0]  cand;

    assign step = by_age[s_q.age];
    assign cand = s_q.prev + {{(ADDR_W - DELTA_W){step[DELTA_W-1]}}, step};

    // ---------------- replacement ----------------
    logic          touch;
    logic [IW-1:0] touch_idx;
    logic [IW-1:0] victim;

    dcpt_lru #(.N(ENTRIES)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    // ---------------- issue queue ----------------
    logic              q_push;
    logic [ADDR_W-1:0] q_data;

    dcpt_pfq #(.DEPTH(QDEPTH), .W(ADDR_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_data),
        .pop       (pf_ready),
        .out_valid (pf_valid),
        .out_data  (pf_addr)
    );

    assign acc_ready = (s_q.st == ST_IDLE);

    // ---------------- next state ----------------
    always_comb begin
        s_d       = s_q;
        touch     = 1'b0;
        touch_idx = hit_idx;
        q_push    = 1'b0;
        q_data    = s_q.cbuf[s_q.fidx[CIW-1:0]];
        qry_valid = 1'b0;
        qry_addr  = cand;

        unique case (s_q.st)
            ST_IDLE: begin
                if (acc_valid) begin
                    touch = 1'b1;
                    if (hit) begin
                        touch_idx = hit_idx;
                        if (diff != '0) begin
                            s_d.tbl[hit_idx].lastb       = acc_addr;
                            s_d.tbl[hit_idx].head        = head_nx;
                            s_d.tbl[hit_idx].dl[head_nx] = enc;
                            s_d.sel                      = hit_idx;
                            s_d.st                       = ST_SEARCH;
                        end
                    end else begin
                        touch_idx                   = victim;
                        s_d.tbl[victim].valid       = 1'b1;
                        s_d.tbl[victim].pc          = acc_pc;
                        s_d.tbl[victim].lastb       = acc_addr;
                        s_d.tbl[victim].dl          = '0;
                        s_d.tbl[victim].head        = '0;
                        s_d.tbl[victim].lpf_ok      = 1'b0;
                        s_d.tbl[victim].lpf         = '0;
                    end
                end
            end

            ST_SEARCH: begin
                if (found) begin
                    s_d.st   = ST_GEN;
                    s_d.age  = match_age - HW'(1);
                    s_d.prev = s_q.tbl[s_q.sel].lastb;
                    s_d.ccnt = '0;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end

            ST_GEN: begin
                qry_valid = 1'b1;
                s_d.prev  = cand;
                if (s_q.tbl[s_q.sel].lpf_ok && cand == s_q.tbl[s_q.sel].lpf) begin
                    s_d.ccnt = '0;
                end else if (!qry_in_cache && !qry_in_mshr) begin
                    s_d.cbuf[s_q.ccnt[CIW-1:0]] = cand;
                    s_d.ccnt                    = s_q.ccnt + CBW'(1);
                end
                if (s_q.age == '0) begin
                    s_d.st   = ST_FLUSH;
                    s_d.fidx = '0;
                end else begin
                    s_d.age = s_q.age - HW'(1);
                end
            end

            ST_FLUSH: begin
                if (s_q.ccnt == '0) begin
                    s_d.st = ST_IDLE;
                end else begin
                    q_push                      = 1'b1;
                    s_d.tbl[s_q.sel].lpf_ok     = 1'b1;
                    s_d.tbl[s_q.sel].lpf        = q_data;
                    s_d.fidx                    = s_q.fidx + CBW'(1);
                    if (s_q.fidx == s_q.ccnt - CBW'(1))
                        s_d.st = ST_IDLE;
                end
            end

            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/dcpt_prefetcher_chk.sv
module dcpt_prefetcher_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_ready,
    input logic              qry_valid,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              q_push
);

    // R10: lookups only while the engine is busy
    a_r10_query_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |-> !acc_ready);

    // R10: a query cycle is always followed by another busy cycle
    a_r10_query_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> !acc_ready);

    // R10: survivors reach the queue only while the engine is busy
    a_r10_push_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> !acc_ready);

    // R9: a non-empty queue cannot empty itself without a pop
    a_r9_hold_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> pf_valid);

    // R9: head is steady when neither popped nor displaced
    a_r9_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !q_push) |=> $stable(pf_addr));

    // R1: the queue only becomes non-empty through a push
    a_r1_fill_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(q_push));

endmodule

bind dcpt_prefetcher dcpt_prefetcher_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_ready (acc_ready),
    .qry_valid (qry_valid),
    .pf_valid  (pf_valid),
    .pf_ready  (pf_ready),
    .pf_addr   (pf_addr),
    .q_push    (q_push)
);

// File: tb/tb_dcpt_prefetcher.sv
module tb_dcpt_prefetcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic [31:0] acc_pc = '0;
    logic [31:0] acc_addr = '0;
    logic        qry_valid;
    logic [31:0] qry_addr;
    logic        qry_in_cache;
    logic        qry_in_mshr;
    logic        pf_valid;
    logic        pf_ready = 1'b0;
    logic [31:0] pf_addr;

    // external cache / miss-status models
    logic        c_en = 1'b0;
    logic [31:0] c_blk = '0;
    logic        m_en = 1'b0;
    logic [31:0] m_blk = '0;

    assign qry_in_cache = c_en && (qry_addr == c_blk);
    assign qry_in_mshr  = m_en && (qry_addr == m_blk);

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dcpt_prefetcher dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_ready    (acc_ready),
        .acc_pc       (acc_pc),
        .acc_addr     (acc_addr),
        .qry_valid    (qry_valid),
        .qry_addr     (qry_addr),
        .qry_in_cache (qry_in_cache),
        .qry_in_mshr  (qry_in_mshr),
        .pf_valid     (pf_valid),
        .pf_ready     (pf_ready),
        .pf_addr      (pf_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // offer one access, wait for the engine to go idle, return busy cycles
    task automatic access(input logic [31:0] pc, input logic [31:0] a, output int busy);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_pc    = pc;
        acc_addr  = a;
        @(negedge clk);
        acc_valid = 1'b0;
        busy = 0;
        while (!acc_ready) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic train(input logic [31:0] pc, input logic [31:0] a);
        int b;
        access(pc, a, b);
    endtask

    task automatic expect_pf(input string req, input logic [31:0] exp);
        @(negedge clk);
        check({req, " valid"}, 32'(pf_valid), 32'd1);
        check({req, " addr"}, pf_addr, exp);
        pf_ready = 1'b1;
        @(negedge clk);
        pf_ready = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        check({req, " empty"}, 32'(pf_valid), 32'd0);
    endtask

    task automatic t_reset;
        check("R1 pf_valid", 32'(pf_valid), 32'd0);
        check("R1 acc_ready", 32'(acc_ready), 32'd1);
        check("R1 qry_valid", 32'(qry_valid), 32'd0);
    endtask

    task automatic t_stride;
        int b;
        access(32'h400, 1000, b); check("R2 alloc busy", b, 0);
        access(32'h400, 1010, b); check("R10 nomatch busy", b, 1);
        access(32'h400, 1020, b);
        expect_empty("R5 short history");
        access(32'h400, 1030, b); check("R10 one cand busy", b, 3);
        expect_pf("R5 stride", 1040);
        access(32'h400, 1040, b);
        expect_pf("R5 stride next", 1050);
        expect_empty("R9 drained");
    endtask

    task automatic t_pattern;
        int b;
        train(32'h500, 100); train(32'h500, 101); train(32'h500, 103); train(32'h500, 104);
        expect_empty("R5 no pair yet");
        access(32'h500, 106, b); check("R10 two cand busy", b, 5);
        expect_pf("R5 replay first", 107);
        expect_pf("R5 replay second", 109);
        access(32'h500, 107, b); check("R10 discard busy", b, 4);
        expect_pf("R6 discard before last", 110);
        expect_empty("R6 only one");
        access(32'h500, 109, b);
        expect_pf("R5 nearest match", 112);
        expect_empty("R5 nearest only");
    endtask

    task automatic t_filter;
        int b;
        c_en = 1'b1; c_blk = 228;
        m_en = 1'b1; m_blk = 235;
        train(32'h600, 200); train(32'h600, 207); train(32'h600, 214);
        access(32'h600, 221, b); check("R7 busy", b, 3);
        expect_empty("R7 cached dropped");
        train(32'h600, 228);
        expect_empty("R8 miss pending dropped");
        train(32'h600, 235);
        expect_pf("R7 R8 uncovered kept", 242);
        c_en = 1'b0; m_en = 1'b0;
    endtask

    task automatic t_zero;
        int b;
        train(32'h700, 300); train(32'h700, 305);
        access(32'h700, 305, b); check("R3 zero step busy", b, 0);
        train(32'h700, 310);
        expect_empty("R3 history");
        train(32'h700, 315);
        expect_pf("R3 zero step not stored", 320);
    endtask

    task automatic t_overflow;
        train(32'h800, 0); train(32'h800, 200); train(32'h800, 400); train(32'h800, 600);
        expect_empty("R4 large step");
        train(32'hB00, 0); train(32'hB00, 128); train(32'hB00, 256); train(32'hB00, 384);
        expect_empty("R4 step 128");
        train(32'h900, 1000); train(32'h900, 1127); train(32'h900, 1254); train(32'h900, 1381);
        expect_pf("R4 step 127", 1508);
        train(32'hA00, 5000); train(32'hA00, 4872); train(32'hA00, 4744); train(32'hA00, 4616);
        expect_pf("R4 step -128", 4488);
    endtask

    task automatic t_lru;
        train(32'hC00, 10); train(32'hC00, 11); train(32'hC00, 12);
        for (int i = 0; i < 7; i++) train(32'hD000 + 32'(i * 16), 7);
        train(32'hC00, 13);
        expect_pf("R2 kept entry", 14);
        train(32'hE00, 50); train(32'hE00, 52); train(32'hE00, 54);
        for (int i = 0; i < 8; i++) train(32'hF000 + 32'(i * 16), 9);
        train(32'hE00, 56);
        expect_empty("R2 evicted entry");
    endtask

    task automatic t_queue;
        for (int i = 0; i <= 36; i++) train(32'h2000, 10000 + 32'(i));
        for (int i = 0; i < 32; i++) expect_pf("R9 oldest dropped", 10006 + 32'(i));
        expect_empty("R9 depth 32");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stride();
        t_pattern();
        t_filter();
        t_zero();
        t_overflow();
        t_lru();
        t_queue();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule